// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Generation

This block is the shift and rotate datapath of an integer execution pipe. Each cycle it may accept one operation: a left shift, a plain rotate left or right, or a rotate left or right through the carry flag. The operand may be 8, 16 or 32 bits wide. The block computes the result, the new carry and overflow flags and, for the left shift, the sign, zero and parity flags. Every output has its own write or update enable, so the register file and the flag register can leave untouched whatever the operation does not change.

The count is handled the way the integer instruction set defines it. The count is first reduced to its low 5 bits. A rotate through carry then takes it modulo the operand width plus one. A plain rotate takes it modulo the operand width. When a plain rotate's count is a non-zero multiple of the width, no result is written, but carry and overflow are still updated from the unchanged operand. The outputs are registered: the result of an operation presented at one rising edge appears after that edge and stays until the next one.

Top module: `shrot_unit`

## Requirements
- R1: While rst_ni is low, every output is 0, all enables included.
- R2: The outputs after a rising edge reflect the inputs sampled at that edge. With valid_i low, result_we_o, carry_we_o, ovf_we_o and szp_we_o are all 0.
- R3: op_i encodings are 0 = shift left, 1 = rotate left, 2 = rotate right, 3 = rotate left through carry, 4 = rotate right through carry. size_i encodings are 0 = 8, 1 = 16, 2 = 32 bits. For the shift left, the count is masked to count_i[4:0]. A masked count of 0 raises no enable. Otherwise result_o = operand << count, carry_o = the last bit shifted out, ovf_o = carry_o XOR the result's top bit, and the result, carry, overflow and sign/zero/parity enables are all 1.
- R4: An 8- or 16-bit shift left by a masked count equal to the width gives result 0 with carry = operand bit 0. A masked count larger than the width gives result 0 and carry 0.
- R5: On a shift left, sign_o = the result's top bit, zero_o = 1 when the result is 0, and parity_o = 1 when result bits 7:0 hold an even number of ones.
- R6: A rotate right by count_i[4:0] mod width writes the rotated value. carry_o = the result's top bit, and ovf_o = the XOR of the two top result bits.
- R7: A rotate left by count_i[4:0] mod width writes the rotated value. carry_o = result bit 0, and ovf_o = bit 0 XOR the top bit.
- R8: An 8-bit plain rotate with count_i[2:0] = 0 and count_i[4:3] non-zero writes no result. carry_we_o and ovf_we_o are 1, with the flags taken from the unchanged operand under the rules of R6/R7.
- R9: A 16-bit plain rotate with count_i[3:0] = 0 and count_i[4] = 1 behaves as in R8.
- R10: A 32-bit plain rotate, or any plain rotate whose count_i[4:0] = 0, raises no enable when count_i[4:0] = 0.
- R11: A rotate right through carry uses n = count_i[4:0] mod 9 for 8 bits, mod 17 for 16 bits, and count_i[4:0] for 32 bits. n = 0 raises no enable. Otherwise the value {carry_i, operand} is rotated right by n. The new carry is operand bit n-1, and ovf_o = the XOR of the two top result bits.
- R12: A rotate left through carry uses the same n. {carry_i, operand} is rotated left by n, the new carry is operand bit (width-n), and ovf_o = the new carry XOR the result's top bit.
- R13: An op_i above 4 or a size_i of 3 raises no enable.
- R14: szp_we_o is 1 only for the shift left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (see R3) |
| size_i | input | 2 | Operand size code (see R3) |
| operand_i | input | 32 | Operand; bits above the size are ignored |
| count_i | input | 8 | Shift or rotate count |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Result, zero-extended above the size |
| result_we_o | output | 1 | Result must be written |
| carry_o | output | 1 | New carry flag |
| carry_we_o | output | 1 | Carry flag update enable |
| ovf_o | output | 1 | New overflow flag |
| ovf_we_o | output | 1 | Overflow flag update enable |
| sign_o | output | 1 | Sign of the shift-left result |
| zero_o | output | 1 | Shift-left result is zero |
| parity_o | output | 1 | Even parity of the low result byte |
| szp_we_o | output | 1 | Sign/zero/parity update enable |

## Verification
The assertions assume that valid_i, op_i, size_i and count_i are known, not X, at every rising edge after reset. They do not assume that op_i or size_i hold a legal code: an illegal code must simply raise no enable. The bench drives every input at the falling edge and keeps all of them at defined values in every cycle. It includes idle cycles and illegal codes on purpose, so the no-enable properties are exercised.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int OP_W   = 3;
  localparam int SIZE_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_SHL = 3'd0,
    OP_ROL = 3'd1,
    OP_ROR = 3'd2,
    OP_RCL = 3'd3,
    OP_RCR = 3'd4
  } shrot_op_e;
endpackage

// File: rtl/shrot_szp.sv
module shrot_szp #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         sign_o,
  output logic         zero_o,
  output logic         parity_o
);
  assign sign_o   = res_i[W-1];
  assign zero_o   = ~|res_i;
  assign parity_o = ~^res_i[7:0];
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 5
) (
  input  shrot_op_e        op_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [W-1:0]     val_i,
  input  logic             carry_i,
  output logic [W-1:0]     res_o,
  output logic             we_o,
  output logic             cf_o,
  output logic             cf_we_o,
  output logic             of_o,
  output logic             of_we_o,
  output logic             szp_we_o,
  output logic             sign_o,
  output logic             zero_o,
  output logic             parity_o
);
  localparam int AMT_W = $clog2(W);
  localparam int RC_N  = W + 1;

  logic [AMT_W-1:0] amt;
  logic             cnt_nz;
  logic             wrap;
  logic [CNT_W-1:0] rc_cnt;

  assign amt    = cnt_i[AMT_W-1:0];
  assign cnt_nz = |cnt_i;
  assign wrap   = cnt_nz && (amt == '0);
  assign rc_cnt = CNT_W'(int'(cnt_i) % RC_N);

  // shift left: extra top bit catches the last bit shifted out
  logic [W:0] shl_x;
  assign shl_x = {1'b0, val_i} << cnt_i;

  // plain rotates on a doubled operand
  logic [2*W-1:0] rot2, rol_x, ror_x;
  assign rot2  = {val_i, val_i};
  assign rol_x = rot2 << amt;
  assign ror_x = rot2 >> amt;

  // through-carry rotates on a doubled {carry, operand}
  logic [2*W+1:0] rc2, rcl_x, rcr_x;
  assign rc2   = {carry_i, val_i, carry_i, val_i};
  assign rcl_x = rc2 << rc_cnt;
  assign rcr_x = rc2 >> rc_cnt;

  logic [W-1:0] rol_r, ror_r;
  assign rol_r = rol_x[2*W-1:W];
  assign ror_r = ror_x[W-1:0];

  always_comb begin
    res_o    = val_i;
    we_o     = 1'b0;
    cf_o     = 1'b0;
    of_o     = 1'b0;
    cf_we_o  = 1'b0;
    of_we_o  = 1'b0;
    szp_we_o = 1'b0;
    unique case (op_i)
      OP_SHL: if (cnt_nz) begin
        res_o    = shl_x[W-1:0];
        cf_o     = shl_x[W];
        of_o     = shl_x[W] ^ shl_x[W-1];
        we_o     = 1'b1;
        cf_we_o  = 1'b1;
        of_we_o  = 1'b1;
        szp_we_o = 1'b1;
      end
      OP_ROL: if (cnt_nz) begin
        res_o   = rol_r;
        we_o    = !wrap;
        cf_o    = rol_r[0];
        of_o    = rol_r[0] ^ rol_r[W-1];
        cf_we_o = 1'b1;
        of_we_o = 1'b1;
      end
      OP_ROR: if (cnt_nz) begin
        res_o   = ror_r;
        we_o    = !wrap;
        cf_o    = ror_r[W-1];
        of_o    = ror_r[W-1] ^ ror_r[W-2];
        cf_we_o = 1'b1;
        of_we_o = 1'b1;
      end
      OP_RCL: if (rc_cnt != '0) begin
        res_o   = rcl_x[2*W:W+1];
        cf_o    = rcl_x[2*W+1];
        of_o    = rcl_x[2*W+1] ^ rcl_x[2*W];
        we_o    = 1'b1;
        cf_we_o = 1'b1;
        of_we_o = 1'b1;
      end
      OP_RCR: if (rc_cnt != '0) begin
        res_o   = rcr_x[W-1:0];
        cf_o    = rcr_x[W];
        of_o    = rcr_x[W-1] ^ rcr_x[W-2];
        we_o    = 1'b1;
        cf_we_o = 1'b1;
        of_we_o = 1'b1;
      end
      default: ;
    endcase
  end

  shrot_szp #(.W(W)) u_szp (
    .res_i   (res_o),
    .sign_o  (sign_o),
    .zero_o  (zero_o),
    .parity_o(parity_o)
  );
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [DATA_W-1:0]  operand_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               result_we_o,
  output logic               carry_o,
  output logic               carry_we_o,
  output logic               ovf_o,
  output logic               ovf_we_o,
  output logic               sign_o,
  output logic               zero_o,
  output logic               parity_o,
  output logic               szp_we_o
);
  localparam int CNT_W   = $clog2(DATA_W);
  localparam int N_SIZES = $clog2(DATA_W / 8) + 1;

  shrot_op_e        op;
  logic [CNT_W-1:0] cnt;
  logic             op_ok;

  assign op    = shrot_op_e'(op_i);
  assign cnt   = count_i[CNT_W-1:0];
  assign op_ok = (op_i <= OP_W'(OP_RCR));

  logic [DATA_W-1:0] l_res [N_SIZES];
  logic [N_SIZES-1:0] l_we, l_cf, l_cf_we, l_of, l_of_we, l_szp_we, l_s, l_z, l_p;

  for (genvar g = 0; g < N_SIZES; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] res;
    shrot_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
      .op_i    (op),
      .cnt_i   (cnt),
      .val_i   (operand_i[LW-1:0]),
      .carry_i (carry_i),
      .res_o   (res),
      .we_o    (l_we[g]),
      .cf_o    (l_cf[g]),
      .cf_we_o (l_cf_we[g]),
      .of_o    (l_of[g]),
      .of_we_o (l_of_we[g]),
      .szp_we_o(l_szp_we[g]),
      .sign_o  (l_s[g]),
      .zero_o  (l_z[g]),
      .parity_o(l_p[g])
    );
    assign l_res[g] = DATA_W'(res);
  end

  logic [DATA_W-1:0] n_res;
  logic n_we, n_cf, n_cf_we, n_of, n_of_we, n_s, n_z, n_p, n_szp_we;

  always_comb begin
    n_res = '0; n_we = 1'b0; n_cf = 1'b0; n_cf_we = 1'b0; n_of = 1'b0;
    n_of_we = 1'b0; n_s = 1'b0; n_z = 1'b0; n_p = 1'b0; n_szp_we = 1'b0;
    for (int i = 0; i < N_SIZES; i++) begin
      if (int'(size_i) == i) begin
        n_res    = l_res[i];
        n_we     = l_we[i];
        n_cf     = l_cf[i];
        n_cf_we  = l_cf_we[i];
        n_of     = l_of[i];
        n_of_we  = l_of_we[i];
        n_s      = l_s[i];
        n_z      = l_z[i];
        n_p      = l_p[i];
        n_szp_we = l_szp_we[i];
      end
    end
  end

  logic go;
  assign go = valid_i && op_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      result_we_o <= 1'b0;
      carry_o     <= 1'b0;
      carry_we_o  <= 1'b0;
      ovf_o       <= 1'b0;
      ovf_we_o    <= 1'b0;
      sign_o      <= 1'b0;
      zero_o      <= 1'b0;
      parity_o    <= 1'b0;
      szp_we_o    <= 1'b0;
    end else begin
      result_o    <= n_res;
      result_we_o <= go && n_we;
      carry_o     <= n_cf;
      carry_we_o  <= go && n_cf_we;
      ovf_o       <= n_of;
      ovf_we_o    <= go && n_of_we;
      sign_o      <= n_s;
      zero_o      <= n_z;
      parity_o    <= n_p;
      szp_we_o    <= go && n_szp_we;
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [2:0]         op_i,
  input logic [1:0]         size_i,
  input logic [DATA_W-1:0]  operand_i,
  input logic [COUNT_W-1:0] count_i,
  input logic               carry_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               result_we_o,
  input logic               carry_o,
  input logic               carry_we_o,
  input logic               ovf_o,
  input logic               ovf_we_o,
  input logic               sign_o,
  input logic               zero_o,
  input logic               parity_o,
  input logic               szp_we_o
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!result_we_o && !carry_we_o && !ovf_we_o && !szp_we_o);
    end
  end

  a_r2_idle_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !result_we_o && !carry_we_o && !ovf_we_o && !szp_we_o);

  a_r3_shl_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd0 && count_i[4:0] == 5'd0 |=> !result_we_o && !carry_we_o);

  a_r3_write_has_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_we_o |-> carry_we_o && ovf_we_o);

  a_r5_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    szp_we_o |-> zero_o == (result_o == '0));

  a_r8_byte_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd1 || op_i == 3'd2) && size_i == 2'd0 &&
    count_i[2:0] == 3'd0 && count_i[4:3] != 2'd0 |=> !result_we_o && carry_we_o && ovf_we_o);

  a_r9_half_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd1 || op_i == 3'd2) && size_i == 2'd1 &&
    count_i[4:0] == 5'h10 |=> !result_we_o && carry_we_o);

  a_r13_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i > 3'd4 || size_i == 2'd3) |=> !carry_we_o && !result_we_o && !szp_we_o);

  a_r14_szp_shl_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != 3'd0 |=> !szp_we_o);
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_chk (.*);

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
  typedef struct packed {
    logic [31:0] res;
    logic we, cwe, c, owe, o, swe, s, z, p;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] operand_i = '0;
  logic [7:0]  count_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        result_we_o, carry_o, carry_we_o, ovf_o, ovf_we_o;
  logic        sign_o, zero_o, parity_o, szp_we_o;

  int n_chk = 0;
  int n_fail = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk_i = ~clk_i;

  shrot_unit uut (.*);

  function automatic exp_t model(int op, int sz, logic [31:0] v, logic [7:0] cnt,
                                 bit cin, bit vld);
    exp_t e;
    int w, c5, n;
    logic [31:0] mask, r;
    bit c, nc;
    e = '0;
    if (!vld || sz > 2 || op > 4) return e;
    w = 8 << sz;
    mask = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 1);
    r = v & mask;
    c5 = int'(cnt & 8'h1f);
    e.res = r;
    case (op)
      0: if (c5 != 0) begin
        c = 1'b0;
        for (int i = 0; i < c5; i++) begin c = r[w-1]; r = (r << 1) & mask; end
        e.res = r; e.we = 1; e.cwe = 1; e.c = c; e.owe = 1; e.o = c ^ r[w-1];
        e.swe = 1; e.s = r[w-1]; e.z = (r == 0); e.p = ~^r[7:0];
      end
      1, 2: if (c5 != 0) begin
        n = c5 % w;
        for (int i = 0; i < n; i++) begin
          if (op == 1) r = ((r << 1) | (r >> (w - 1))) & mask;
          else         r = (r >> 1) | ((r & 32'd1) << (w - 1));
        end
        e.res = r; e.we = (n != 0); e.cwe = 1; e.owe = 1;
        if (op == 1) begin e.c = r[0]; e.o = r[0] ^ r[w-1]; end
        else begin e.c = r[w-1]; e.o = r[w-1] ^ r[w-2]; end
      end
      default: begin
        n = c5 % (w + 1);
        if (n != 0) begin
          c = cin;
          for (int i = 0; i < n; i++) begin
            if (op == 3) begin nc = r[w-1]; r = ((r << 1) | 32'(c)) & mask; end
            else begin nc = r[0]; r = (r >> 1) | (32'(c) << (w - 1)); end
            c = nc;
          end
          e.res = r; e.we = 1; e.cwe = 1; e.c = c; e.owe = 1;
          e.o = (op == 3) ? (c ^ r[w-1]) : (r[w-1] ^ r[w-2]);
        end
      end
    endcase
    return e;
  endfunction

  task automatic drive(string tag, bit vld, int op, int sz, logic [31:0] v,
                       logic [7:0] cnt, bit cin);
    @(negedge clk_i);
    valid_i = vld; op_i = 3'(op); size_i = 2'(sz);
    operand_i = v; count_i = cnt; carry_i = cin;
    exp_q.push_back(model(op, sz, v, cnt, cin, vld));
    tag_q.push_back(tag);
  endtask

  function automatic string op_tag(int op);
    case (op)
      0: return "R3";
      1: return "R7";
      2: return "R6";
      3: return "R12";
      default: return "R11";
    endcase
  endfunction

  // monitor: compare one item per edge after the outputs settle
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e, a;
      string t;
      bit bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '0;
      a.we = result_we_o; a.cwe = carry_we_o; a.owe = ovf_we_o; a.swe = szp_we_o;
      a.res = result_we_o ? result_o : e.res;
      a.c = carry_we_o ? carry_o : e.c;
      a.o = ovf_we_o ? ovf_o : e.o;
      a.s = szp_we_o ? sign_o : e.s;
      a.z = szp_we_o ? zero_o : e.z;
      a.p = szp_we_o ? parity_o : e.p;
      bad = (a !== e);
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: actual res=%h we=%b cwe=%b c=%b owe=%b o=%b swe=%b s=%b z=%b p=%b expected res=%h we=%b cwe=%b c=%b owe=%b o=%b swe=%b s=%b z=%b p=%b",
                 t, a.res, a.we, a.cwe, a.c, a.owe, a.o, a.swe, a.s, a.z, a.p,
                 e.res, e.we, e.cwe, e.c, e.owe, e.o, e.swe, e.s, e.z, e.p);
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if ({result_o, result_we_o, carry_we_o, ovf_we_o, szp_we_o} !== '0) begin
      n_fail++;
      $display("FAIL R1: actual res=%h enables=%b expected all zero", result_o,
               {result_we_o, carry_we_o, ovf_we_o, szp_we_o});
    end
    rst_ni = 1'b1;

    // R3 basic shift left and masking of count
    drive("R3", 1, 0, 0, 32'h81, 8'd1, 0);
    drive("R3", 1, 0, 0, 32'h81, 8'h20, 1);
    drive("R3", 1, 0, 2, 32'h8000_0001, 8'd31, 0);
    drive("R3", 1, 0, 1, 32'hffff_1234, 8'h23, 0);
    // R4 shift by width and beyond
    drive("R4", 1, 0, 0, 32'h01, 8'd8, 0);
    drive("R4", 1, 0, 0, 32'hff, 8'd9, 0);
    drive("R4", 1, 0, 1, 32'h0001, 8'd16, 0);
    drive("R4", 1, 0, 1, 32'hffff, 8'd20, 0);
    // R5 sign / zero / parity
    drive("R5", 1, 0, 0, 32'h40, 8'd1, 0);
    drive("R5", 1, 0, 0, 32'h80, 8'd1, 0);
    drive("R5", 1, 0, 1, 32'h0033, 8'd2, 0);
    // R6 / R7 plain rotates
    drive("R6", 1, 2, 0, 32'h01, 8'd1, 0);
    drive("R6", 1, 2, 2, 32'h0000_0003, 8'd4, 0);
    drive("R7", 1, 1, 1, 32'h8000, 8'd1, 0);
    drive("R7", 1, 1, 0, 32'h81, 8'd3, 1);
    // R8 byte wrap: no write, flags from unchanged value
    drive("R8", 1, 1, 0, 32'h81, 8'd8, 0);
    drive("R8", 1, 2, 0, 32'h40, 8'h18, 0);
    drive("R8", 1, 1, 0, 32'h81, 8'h20, 0);
    // R9 half-word wrap
    drive("R9", 1, 1, 1, 32'h0001, 8'd16, 0);
    drive("R9", 1, 2, 1, 32'h4000, 8'h10, 0);
    // R10 32-bit rotate count handling
    drive("R10", 1, 2, 2, 32'h1234_5678, 8'd32, 0);
    drive("R10", 1, 1, 2, 32'h8000_0000, 8'd33, 0);
    // R11 rotate right through carry with modulo
    drive("R11", 1, 4, 0, 32'h5a, 8'd9, 1);
    drive("R11", 1, 4, 0, 32'h01, 8'd10, 1);
    drive("R11", 1, 4, 1, 32'h1234, 8'd17, 0);
    drive("R11", 1, 4, 0, 32'h96, 8'd31, 1);
    // R12 rotate left through carry
    drive("R12", 1, 3, 0, 32'h80, 8'd1, 1);
    drive("R12", 1, 3, 1, 32'h8001, 8'd18, 0);
    drive("R12", 1, 3, 2, 32'hc000_0000, 8'd2, 1);
    // R13 illegal codes, R2 idle, R14 rotate leaves szp alone
    drive("R13", 1, 5, 0, 32'hff, 8'd1, 1);
    drive("R13", 1, 0, 3, 32'hff, 8'd1, 1);
    drive("R2", 0, 0, 0, 32'hff, 8'd1, 1);
    drive("R14", 1, 3, 0, 32'h00, 8'd1, 0);

    for (int i = 0; i < 400; i++) begin
      int op, sz;
      op = int'($urandom_range(0, 4));
      sz = int'($urandom_range(0, 2));
      drive(op_tag(op), 1, op, sz, $urandom, 8'($urandom), 1'($urandom));
    end
    drive("R2", 0, 0, 0, 32'h0, 8'd0, 0);
    repeat (4) @(negedge clk_i);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: actual pending=%0d expected pending=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule